// File: doc/BRIEF.md
# Sector Transfer Request and Interrupt Controller

This block is the device-side sequencer for a multi-sector data move between a storage device and a host. A command is loaded with a sector count and a transfer mode. In DMA mode the block drives an active-low request line that asks the host's DMA engine for words. In programmed mode the request line stays idle and the host moves each word under software control. Each host word transfer is reported to the block as a one-cycle strobe. The block counts sectors of 256 sixteen-bit words. It reports busy for the length of the command and raises an active-low interrupt.

Interrupt timing depends on the mode. In DMA mode the interrupt comes only once, when the whole command has finished. In programmed mode it comes after every sector. The request line is dropped a programmable number of words before the end of each sector, so that a host that reacts late does not fetch words past the sector boundary. A media failure ends the command early and still signals completion. A soft-reset bit aborts the command: the request drops in the same cycle, no interrupt is raised, and busy is held until the bit has been released for two clocks.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After synchronous reset, busy is 0, dmarq_n is 1 and irq_n is 1.
- R2: A start pulse with a nonzero sector_count while the block is idle and srst is 0 sets busy from the next clock. A start pulse with sector_count 0, or one that arrives while busy, has no effect.
- R3: A command ends after exactly sector_count × 256 word strobes. Busy reads 0 in the cycle after the clock edge that samples the last strobe.
- R4: In DMA mode (dma_mode=1 at start), dmarq_n is 0 while the words still to move in the current sector exceed neg_early, and 1 otherwise. In programmed mode (dma_mode=0) dmarq_n is always 1.
- R5: When a sector ends and more sectors remain, the word count reloads to 256, so dmarq_n returns to 0 for the next sector in DMA mode.
- R6: In DMA mode irq_n falls only when the whole command completes. It stays 1 at the boundaries between sectors.
- R7: In programmed mode irq_n falls at the end of every sector, including the last one.
- R8: Once low, irq_n stays low until a status_rd pulse is sampled. If a new interrupt event and status_rd fall in the same cycle, the event wins and irq_n stays low.
- R9: A fail pulse during a transfer ends the command at once: busy reads 0 and irq_n reads 0 after that edge, although fewer words were moved.
- R10: srst=1 during a command forces dmarq_n to 1 in the same cycle, raises no interrupt, and keeps busy at 1 for as long as srst stays high.
- R11: After srst returns to 0 following an abort, busy stays 1 for two clock edges and reads 0 after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start pulse |
| sector_count | input | 8 | Number of 256-word sectors to move |
| dma_mode | input | 1 | 1 = DMA transfer, 0 = programmed transfer (sampled at start) |
| neg_early | input | 4 | Words before the end of a sector at which the request is dropped |
| word_strobe | input | 1 | One host word transferred this cycle |
| fail | input | 1 | Media failure pulse; ends the command early |
| srst | input | 1 | Soft-reset bit from the device control register |
| status_rd | input | 1 | Host status read; clears the interrupt |
| dmarq_n | output | 1 | Active-low DMA request, level signalled |
| irq_n | output | 1 | Active-low interrupt |
| busy | output | 1 | Command in progress |

## Verification
Commands are issued in both modes with random sector counts, random early-negation values and random idle gaps between word strobes. The request line is compared against a bench function of the mode, the words still to move in the sector and the negation value. The gaps show that the request depends on how many words have moved and not on elapsed time. Sector-boundary checks of the interrupt separate the per-sector behaviour of programmed mode from the end-only behaviour of DMA mode. Directed runs then cover the following cases:
- an early-negation value of zero
- a repeated start during a transfer
- a status read that coincides with an interrupt event
- a mid-sector failure
- a mid-sector abort, with the busy release counted edge by edge

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_ABORT,
        ST_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic blk_done;
        logic cmd_done;
    } seq_evt_t;

    // Request window: asserted while more words remain than the early-negation value.
    function automatic logic req_window(input logic [15:0] left, input logic [15:0] early);
        return left > early;
    endfunction

    // Whether a completion event raises the interrupt in the given mode.
    function automatic logic irq_event(input seq_evt_t ev, input logic dma);
        return ev.cmd_done | (ev.blk_done & ~dma);
    endfunction

endpackage

// File: rtl/dmairq_seq.sv
module dmairq_seq
    import dmairq_pkg::*;
#(
    parameter int WPS        = 256,
    parameter int SEC_W      = 8,
    parameter int DRAIN_CLKS = 2,
    localparam int WORD_W    = $clog2(WPS + 1),
    localparam int DRAIN_W   = $clog2(DRAIN_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEC_W-1:0]  sector_count,
    input  logic              dma_mode,
    input  logic              word_strobe,
    input  logic              fail,
    input  logic              srst,
    output logic              xfer,
    output logic              busy,
    output logic              mode_dma,
    output logic [WORD_W-1:0] words_left,
    output seq_evt_t          evt
);

    seq_state_e         st_q;
    logic [SEC_W-1:0]   sec_q;
    logic [WORD_W-1:0]  wl_q;
    logic [DRAIN_W-1:0] drn_q;
    logic               mode_q;

    always_comb begin
        evt = '0;
        if (st_q == ST_XFER && !srst) begin
            if (fail) begin
                evt.cmd_done = 1'b1;
            end else if (word_strobe && wl_q == WORD_W'(1)) begin
                evt.blk_done = 1'b1;
                evt.cmd_done = (sec_q == SEC_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sec_q  <= '0;
            wl_q   <= '0;
            drn_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start && !srst && sector_count != '0) begin
                        st_q   <= ST_XFER;
                        sec_q  <= sector_count;
                        wl_q   <= WORD_W'(WPS);
                        mode_q <= dma_mode;
                    end
                end
                ST_XFER: begin
                    if (srst) begin
                        st_q <= ST_ABORT;
                    end else if (evt.cmd_done) begin
                        st_q <= ST_IDLE;
                        wl_q <= '0;
                    end else if (evt.blk_done) begin
                        sec_q <= sec_q - SEC_W'(1);
                        wl_q  <= WORD_W'(WPS);
                    end else if (word_strobe) begin
                        wl_q <= wl_q - WORD_W'(1);
                    end
                end
                ST_ABORT: begin
                    wl_q <= '0;
                    if (!srst) begin
                        st_q  <= ST_DRAIN;
                        drn_q <= DRAIN_W'(DRAIN_CLKS - 1);
                    end
                end
                default: begin
                    if (drn_q == '0) st_q <= ST_IDLE;
                    else             drn_q <= drn_q - DRAIN_W'(1);
                end
            endcase
        end
    end

    assign xfer       = (st_q == ST_XFER);
    assign busy       = (st_q != ST_IDLE);
    assign mode_dma   = mode_q;
    assign words_left = wl_q;

    // R3: an active transfer always has at least one word left in its sector
    p_words_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_XFER) |-> (wl_q != '0));

    // R11: while the release countdown runs, busy holds
    p_drain_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRAIN && drn_q != '0) |=> busy);

    // R10: a held soft reset keeps the block out of idle
    p_abort_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ABORT && srst) |=> (st_q == ST_ABORT));

endmodule

// File: rtl/dmairq_req.sv
module dmairq_req
    import dmairq_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int NEG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer,
    input  logic              mode_dma,
    input  logic              srst,
    input  logic [WORD_W-1:0] words_left,
    input  logic [NEG_W-1:0]  neg_early,
    output logic              dmarq_n
);

    logic req;

    always_comb begin
        req = xfer && mode_dma && !srst
              && req_window(16'(words_left), 16'(neg_early));
    end

    assign dmarq_n = ~req;

    // R10: soft reset removes the request in the same cycle
    p_srst_drops_req_r10: assert property (@(posedge clk) disable iff (rst)
        srst |-> dmarq_n);

    // R4: no request is issued in programmed mode
    p_pio_no_req_r4: assert property (@(posedge clk) disable iff (rst)
        !mode_dma |-> dmarq_n);

endmodule

// File: rtl/dmairq_irq.sv
module dmairq_irq
    import dmairq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_evt_t evt,
    input  logic     mode_dma,
    input  logic     status_rd,
    output logic     irq_n
);

    logic pend_q;
    logic set;

    assign set = irq_event(evt, mode_dma);

    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (set)       pend_q <= 1'b1;
        else if (status_rd) pend_q <= 1'b0;
    end

    assign irq_n = ~pend_q;

    // R8: the interrupt is released only through a status read
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !status_rd) |=> !irq_n);

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dmairq_pkg::*;
#(
    parameter int WPS        = 256,
    parameter int SEC_W      = 8,
    parameter int NEG_W      = 4,
    parameter int DRAIN_CLKS = 2,
    localparam int WORD_W    = $clog2(WPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEC_W-1:0] sector_count,
    input  logic             dma_mode,
    input  logic [NEG_W-1:0] neg_early,
    input  logic             word_strobe,
    input  logic             fail,
    input  logic             srst,
    input  logic             status_rd,
    output logic             dmarq_n,
    output logic             irq_n,
    output logic             busy
);

    logic              xfer;
    logic              mode_dma;
    logic [WORD_W-1:0] words_left;
    seq_evt_t          evt;

    dmairq_seq #(
        .WPS        (WPS),
        .SEC_W      (SEC_W),
        .DRAIN_CLKS (DRAIN_CLKS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sector_count (sector_count),
        .dma_mode     (dma_mode),
        .word_strobe  (word_strobe),
        .fail         (fail),
        .srst         (srst),
        .xfer         (xfer),
        .busy         (busy),
        .mode_dma     (mode_dma),
        .words_left   (words_left),
        .evt          (evt)
    );

    dmairq_req #(
        .WORD_W (WORD_W),
        .NEG_W  (NEG_W)
    ) u_req (
        .clk        (clk),
        .rst        (rst),
        .xfer       (xfer),
        .mode_dma   (mode_dma),
        .srst       (srst),
        .words_left (words_left),
        .neg_early  (neg_early),
        .dmarq_n    (dmarq_n)
    );

    dmairq_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .mode_dma  (mode_dma),
        .status_rd (status_rd),
        .irq_n     (irq_n)
    );

    // R4: a request is only ever raised during a command
    p_req_needs_busy_r4: assert property (@(posedge clk) disable iff (rst)
        !dmarq_n |-> busy);

    // R6: in DMA mode the interrupt only falls once the command has ended
    p_dma_irq_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_n) && $past(mode_dma)) |-> !busy);

    // R10: an abort never raises the interrupt
    p_abort_no_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && srst && !status_rd) |=> !$fell(irq_n));

endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;

    localparam int WPS = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] sector_count = '0;
    logic       dma_mode = 1'b0;
    logic [3:0] neg_early = '0;
    logic       word_strobe = 1'b0;
    logic       fail = 1'b0;
    logic       srst = 1'b0;
    logic       status_rd = 1'b0;
    logic       dmarq_n;
    logic       irq_n;
    logic       busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_irq_ctrl u_dma_irq_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sector_count (sector_count),
        .dma_mode     (dma_mode),
        .neg_early    (neg_early),
        .word_strobe  (word_strobe),
        .fail         (fail),
        .srst         (srst),
        .status_rd    (status_rd),
        .dmarq_n      (dmarq_n),
        .irq_n        (irq_n),
        .busy         (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected request level from the words already moved in the sector.
    function automatic int exp_req_n(input bit dma, input int moved, input int neg);
        return (dma && (WPS - moved) > neg) ? 0 : 1;
    endfunction

    task automatic clear_irq();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk("R8 cleared by status read", irq_n, 1);
    endtask

    // Run one command; fail_at / abort_at / restart_at are word indexes, -1 for none.
    task automatic run_cmd(input bit dma, input int nsec, input int neg,
                           input int fail_at, input int abort_at,
                           input int restart_at, input bit rd_collide);
        neg_early    = 4'(neg);
        dma_mode     = dma;
        sector_count = 8'(nsec);
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        for (int s = 0; s < nsec; s++) begin
            for (int w = 0; w < WPS; w++) begin
                int idx = s * WPS + w;
                if (idx == fail_at) begin
                    fail = 1'b1;
                    @(negedge clk);
                    fail = 1'b0;
                    chk("R9 busy after fail", busy, 0);
                    chk("R9 irq after fail", irq_n, 0);
                    clear_irq();
                    return;
                end
                if (idx == abort_at) begin
                    srst = 1'b1;
                    #1;
                    chk("R10 request dropped at once", dmarq_n, 1);
                    for (int k = 0; k < 4; k++) begin
                        @(negedge clk);
                        chk("R10 busy held", busy, 1);
                        chk("R10 no irq", irq_n, 1);
                    end
                    srst = 1'b0;
                    @(negedge clk);
                    chk("R11 busy after edge 1", busy, 1);
                    @(negedge clk);
                    chk("R11 busy after edge 2", busy, 1);
                    @(negedge clk);
                    chk("R11 busy after edge 3", busy, 0);
                    chk("R10 no irq after abort", irq_n, 1);
                    chk("R10 request idle", dmarq_n, 1);
                    return;
                end
                if (idx == restart_at) begin
                    sector_count = 8'd9;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    chk("R2 restart ignored, still busy", busy, 1);
                end
                chk((w == 0 && s > 0) ? "R5 request at new sector" : "R4 request level",
                    dmarq_n, exp_req_n(dma, w, neg));
                repeat ($urandom % 3) @(negedge clk);
                chk("R4 request steady in gap", dmarq_n, exp_req_n(dma, w, neg));
                word_strobe = 1'b1;
                if (rd_collide && w == WPS - 1) status_rd = 1'b1;
                @(negedge clk);
                word_strobe = 1'b0;
                status_rd   = 1'b0;
            end
            if (s < nsec - 1) begin
                chk("R3 busy between sectors", busy, 1);
                if (dma) begin
                    chk("R6 no irq at sector boundary", irq_n, 1);
                end else begin
                    chk(rd_collide ? "R8 event wins over read" : "R7 irq per sector",
                        irq_n, 0);
                    clear_irq();
                end
            end else begin
                chk("R3 busy clear at end", busy, 0);
                chk(dma ? "R6 irq at command end" : "R7 irq at last sector", irq_n, 0);
                chk("R4 request idle after end", dmarq_n, 1);
                repeat (3) @(negedge clk);
                chk("R8 irq held", irq_n, 0);
                clear_irq();
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy at reset", busy, 0);
        chk("R1 request at reset", dmarq_n, 1);
        chk("R1 irq at reset", irq_n, 1);

        sector_count = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 zero count ignored", busy, 0);
        chk("R2 zero count no irq", irq_n, 1);

        run_cmd(1'b1, 2, 0, -1, -1, -1, 1'b0);
        run_cmd(1'b1, 2, 15, -1, -1, 100, 1'b0);
        run_cmd(1'b0, 3, 4, -1, -1, -1, 1'b1);
        run_cmd(1'b1, 3, 3, 300, -1, -1, 1'b0);
        run_cmd(1'b1, 3, 5, -1, 297, -1, 1'b0);
        run_cmd(1'b0, 2, 2, -1, 40, -1, 1'b0);

        for (int i = 0; i < 8; i++) begin
            run_cmd(1'($urandom % 2), 1 + int'($urandom % 3), int'($urandom % 16),
                    -1, -1, -1, 1'b0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule